// File: doc/BRIEF.md
# SMBus Alert Response Interrupt Unit

This block raises an active-low, open-drain interrupt request for a device that sits on a shared two-wire bus. It also answers the alert response read cycle. When the bus master reads from the alert response address, every device that holds the interrupt line low tries to return its own address. The devices settle the contest bit by bit on the wired-AND data line. The device that sends its whole address has been served and lets go of the interrupt. A device that loses keeps the interrupt low and tries again in the next alert response cycle.

The interrupt request is the OR of the event flags, each gated by its mask bit. Once an interrupt has been served, by a successful alert response or by a clear-interrupt register strobe, the block stays quiet until its cause has gone away. That happens when the masked flags drop to zero or a clear-all strobe arrives. The interrupt pin never changes in the middle of a bus transaction. Requests and clears that arrive while the bus is busy take effect after the STOP.

The block oversamples SCL and SDA on the system clock. Both are assumed synchronous to it. The two outputs are pull-down enables for the open-drain pads.

Top module: `alert_resp_irq`

## Requirements
- R1: While the bus is idle and the unit is armed, `int_pd` becomes 1 one clock after any bit of `evt_flags & evt_mask` is 1, and 0 one clock after that AND is all zero.
- R2: A START followed by the byte 0x19 (address 0001100, read bit 1) while `int_pd` is 1 is acknowledged, with SDA held low for the ninth clock. The unit then sends the byte {OWN_ADDR, 1}, MSB first, one bit per SCL pulse.
- R3: While sending, the unit samples SDA on each SCL rising edge. If it sends a 1 and reads a 0, it drives nothing more for the rest of that transaction. Its `int_pd` stays 1, and it answers the next alert response cycle.
- R4: After it has sent all eight bits of its answer, the unit is disarmed and `int_pd` goes to 0 once the bus is idle after the STOP.
- R5: A one-clock pulse on `clr_int_wr` disarms the unit in the same way as a successful answer.
- R6: A disarmed unit keeps `int_pd` at 0 while any masked flag is still set. It re-arms when the masked flags are all zero or on a `clr_all_wr` pulse.
- R7: `int_pd` changes only while the bus is idle, from a STOP up to the next START. Requests and clears made during a transaction take effect after its STOP.
- R8: A unit whose `int_pd` is 0 at the START neither acknowledges the alert response address nor drives data, so the master reads the byte as 0xFF.
- R9: The unit acknowledges no address byte other than 0x19.
- R10: After reset both `int_pd` and `sda_pd` are 0 and the unit is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level, synchronous to clk |
| sda_i | input | 1 | Bus data level (wired-AND result) |
| evt_flags | input | N_EVT | Pending event flags |
| evt_mask | input | N_EVT | Interrupt enable per flag |
| clr_int_wr | input | 1 | Clear-interrupt register write strobe |
| clr_all_wr | input | 1 | Clear-all-interrupts register write strobe |
| sda_pd | output | 1 | SDA pull-down enable |
| int_pd | output | 1 | Interrupt pull-down enable (1 = line low) |

## Verification
A wrong arm bit or a wrong interrupt latch shows up at `int_pd` within one or two clocks of the first idle cycle after a STOP. A wrong bit counter or shift index garbles the byte the master reads back in that same transaction. When two units arbitrate, a wrong decision shows in two ways. Either the byte read back mixes the two addresses, or the loser's interrupt line is released even though it was never served. A missing idle gate shows as a change on `int_pd` while the master holds a transaction open.

// File: rtl/alert_resp_irq.sv
`timescale 1ns/1ps
module alert_resp_irq #(
  parameter int         N_EVT    = 8,
  parameter logic [6:0] OWN_ADDR = 7'h21,
  parameter logic [6:0] ARA_ADDR = 7'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [N_EVT-1:0] evt_flags,
  input  logic [N_EVT-1:0] evt_mask,
  input  logic             clr_int_wr,
  input  logic             clr_all_wr,
  output logic             sda_pd,
  output logic             int_pd
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_ACKP = 3'd2,
                         S_ACK  = 3'd3, S_SEND = 3'd4, S_WAIT = 3'd5;
  localparam logic [7:0] ARA_BYTE = {ARA_ADDR, 1'b1};
  localparam logic [7:0] TX_BYTE  = {OWN_ADDR, 1'b1};

  logic       scl_q, sda_q;
  logic [2:0] st, cnt;
  logic [6:0] rx;
  logic       part, armed, ara_done;

  wire pend     = |(evt_flags & evt_mask);
  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire tx_bit   = TX_BYTE[3'd7 - cnt];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      rx       <= '0;
      part     <= 1'b0;
      sda_pd   <= 1'b0;
      ara_done <= 1'b0;
    end else begin
      ara_done <= 1'b0;
      if (start_c) begin
        st     <= S_ADDR;
        cnt    <= '0;
        part   <= int_pd;
        sda_pd <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_pd <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (scl_rise) begin
              rx  <= {rx[5:0], sda_i};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7)
                st <= (({rx, sda_i} == ARA_BYTE) && part) ? S_ACKP : S_WAIT;
            end
          S_ACKP:
            if (scl_fall) begin
              sda_pd <= 1'b1;
              st     <= S_ACK;
            end
          S_ACK:
            if (scl_fall) begin
              sda_pd <= ~TX_BYTE[7];
              cnt    <= '0;
              st     <= S_SEND;
            end
          S_SEND:
            if (scl_rise) begin
              if (tx_bit && !sda_i)
                st <= S_WAIT;
              else if (cnt == 3'd7) begin
                st       <= S_WAIT;
                ara_done <= 1'b1;
              end else
                cnt <= cnt + 3'd1;
            end else if (scl_fall)
              sda_pd <= ~tx_bit;
          S_WAIT:
            if (scl_fall) sda_pd <= 1'b0;
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed  <= 1'b1;
      int_pd <= 1'b0;
    end else begin
      if (clr_all_wr || !pend)       armed <= 1'b1;
      else if (ara_done || clr_int_wr) armed <= 1'b0;
      if (st == S_IDLE) int_pd <= armed & pend;
    end
endmodule

module alert_resp_irq_chk #(
  parameter int N_EVT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             scl_q,
  input logic             sda_i,
  input logic [N_EVT-1:0] evt_flags,
  input logic [N_EVT-1:0] evt_mask,
  input logic             sda_pd,
  input logic             int_pd,
  input logic [2:0]       st
);
  localparam logic [2:0] C_IDLE = 3'd0, C_ACK = 3'd3, C_SEND = 3'd4, C_WAIT = 3'd5;

  a_r7_int_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != C_IDLE) |-> $stable(int_pd));

  a_r8_sda_needs_int: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pd |-> (int_pd && (st == C_ACK || st == C_SEND || st == C_WAIT)));

  a_r3_lost_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_SEND && scl_i && !scl_q && !sda_i && !sda_pd) |=> (!sda_pd && st != C_SEND));

  a_r1_rise_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_pd) |-> $past(|(evt_flags & evt_mask)));
endmodule

bind alert_resp_irq alert_resp_irq_chk #(.N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_q(scl_q), .sda_i(sda_i),
  .evt_flags(evt_flags), .evt_mask(evt_mask), .sda_pd(sda_pd),
  .int_pd(int_pd), .st(st)
);

// File: tb/sim_alert_resp_irq.sv
`timescale 1ns/1ps
module sim_alert_resp_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_pd = 1'b0;
  logic [7:0] f0 = 8'h00, m0 = 8'hFF, f1 = 8'h00, m1 = 8'hFF;
  logic clr0 = 1'b0, clra0 = 1'b0, clr1 = 1'b0, clra1 = 1'b0;
  logic pd0, pd1, int0, int1, sda;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign sda = ~(m_pd | pd0 | pd1);

  alert_resp_irq #(.N_EVT(8), .OWN_ADDR(7'h21)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .evt_flags(f0),
    .evt_mask(m0), .clr_int_wr(clr0), .clr_all_wr(clra0), .sda_pd(pd0), .int_pd(int0));
  alert_resp_irq #(.N_EVT(8), .OWN_ADDR(7'h45)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .evt_flags(f1),
    .evt_mask(m1), .clr_int_wr(clr1), .clr_all_wr(clra1), .sda_pd(pd1), .int_pd(int1));

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_pd = 1'b0; scl = 1'b1; wclk(4);
    m_pd = 1'b1; wclk(4);
    scl = 1'b0; wclk(4);
  endtask

  task automatic i2c_stop();
    m_pd = 1'b1; wclk(4);
    scl = 1'b1; wclk(4);
    m_pd = 1'b0; wclk(4);
  endtask

  task automatic bit_out(input logic b);
    m_pd = ~b; wclk(2);
    scl = 1'b1; wclk(4);
    scl = 1'b0; wclk(2);
  endtask

  task automatic bit_in(output logic b);
    m_pd = 1'b0; wclk(2);
    scl = 1'b1; wclk(2);
    b = sda; wclk(2);
    scl = 1'b0; wclk(2);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    acked = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(1'b1);
  endtask

  task automatic ara(output logic acked, output logic [7:0] data);
    i2c_start();
    wr_byte(8'h19, acked);
    rd_byte(data);
    i2c_stop();
    wclk(3);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [7:0] masks [4];
    masks[0] = 8'hFF; masks[1] = 8'h0F; masks[2] = 8'hA5; masks[3] = 8'h00;
    wclk(4);
    rst_n = 1'b1;
    wclk(2);
    chk("R10 int0", int0, 0);
    chk("R10 int1", int1, 0);
    chk("R10 sda", sda, 1);

    for (int mi = 0; mi < 4; mi++)
      for (int f = 0; f < 256; f++) begin
        f0 = f[7:0]; m0 = masks[mi];
        wclk(3);
        chk("R1 masked or", int0, |(f0 & m0));
      end
    f0 = 8'h00; m0 = 8'hFF;
    wclk(3);

    f0 = 8'h01; wclk(3);
    chk("R1 single flag", int0, 1);
    ara(ack, d);
    chk("R2 ack", ack, 1);
    chk("R2 address", d, 8'h43);
    chk("R4 int released", int0, 0);
    wclk(10);
    chk("R6 stays low", int0, 0);
    ara(ack, d);
    chk("R8 no ack", ack, 0);
    chk("R8 no data", d, 8'hFF);
    f0 = 8'h00; wclk(3);
    f0 = 8'h01; wclk(3);
    chk("R6 rearm on clear", int0, 1);

    clr0 = 1'b1; wclk(1); clr0 = 1'b0; wclk(3);
    chk("R5 clear int", int0, 0);
    clra0 = 1'b1; wclk(1); clra0 = 1'b0; wclk(3);
    chk("R6 clear all rearms", int0, 1);

    f1 = 8'h02; wclk(3);
    chk("R1 int1", int1, 1);
    ara(ack, d);
    chk("R3 ack", ack, 1);
    chk("R3 lower address wins", d, 8'h43);
    chk("R3 winner released", int0, 0);
    chk("R3 loser keeps int", int1, 1);
    ara(ack, d);
    chk("R3 loser retry ack", ack, 1);
    chk("R3 loser retry address", d, 8'h8B);
    chk("R4 loser released", int1, 0);

    f1 = 8'h00; wclk(3);
    f1 = 8'h02; wclk(3);
    chk("R6 int1 rearmed", int1, 1);
    i2c_start();
    wr_byte(8'hA0, ack);
    chk("R9 other address", ack, 0);
    i2c_stop();
    wclk(3);
    chk("R9 int1 kept", int1, 1);

    f0 = 8'h00; wclk(3);
    chk("R1 int0 dropped", int0, 0);
    i2c_start();
    wr_byte(8'hA0, ack);
    f0 = 8'h04; wclk(5);
    chk("R7 raise deferred", int0, 0);
    clr1 = 1'b1; wclk(1); clr1 = 1'b0; wclk(5);
    chk("R7 clear deferred", int1, 1);
    i2c_stop();
    wclk(3);
    chk("R7 raise applied", int0, 1);
    chk("R7 clear applied", int1, 0);

    finish_run();
  end
endmodule